// File: doc/BRIEF.md
# Debug Port Control and Status Register

This block is the control and status word of a debug port. A debug link reaches it through a plain register write strobe and a read-data bus that always shows the whole word. Software uses it to ask two external power controllers to power up: one for the debug domain and one for the system domain. It then polls the matching acknowledge bits until both domains report that they are up.

The block also watches the access-port transaction stream. Each transaction begins with a start pulse and ends with a done pulse. Overrun detection is an enable bit that software normally sets only after both power domains have acknowledged. While it is enabled, a start that arrives before the previous transaction has finished sets a sticky overrun flag. An external fault pulse sets a separate sticky error flag. While either sticky flag is set, the block refuses every later access-port start and raises a blocking output. Software clears the flags by writing one to them.

Top module: `dbg_ctrlstat`

## Requirements
- R1: After reset the read word is zero, both power requests are low, the blocking output is low and no transaction is in flight.
- R2: A register write loads the overrun-detect enable from bit 0, the debug power request from bit 28 and the system power request from bit 30. The request outputs always equal bits 28 and 30 of the read word.
- R3: While bit 0 is one, a start that arrives while a transaction is in flight sets the sticky overrun flag (bit 1) on the next edge, unless a done arrives in the same cycle. That start is not issued.
- R4: While bit 0 is zero, a start that arrives during a transaction in flight is issued and the overrun flag stays zero.
- R5: While bit 1 or bit 5 is one, the blocking output is high, no start is issued, and the in-flight state is unchanged by starts.
- R6: Writing one to bit 1 or bit 5 clears that flag. Writing zero there leaves the flag unchanged.
- R7: A flag-setting event in the same cycle as a write-one-to-clear leaves the flag set.
- R8: A fault pulse sets the sticky error flag (bit 5) on the next edge.
- R9: Each acknowledge input appears in the read word (debug at bit 29, system at bit 31) exactly two clock edges after it changes, and not sooner.
- R10: Writes have no effect on the acknowledge bits 29 and 31.
- R11: A start that is issued while idle marks a transaction in flight. A done pulse in the same cycle as a start completes the previous transaction first, so that start is issued without overrun.
- R12: All bits other than 0, 1, 5 and 28 to 31 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register word |
| ap_start | input | 1 | Access-port transaction start pulse |
| ap_done | input | 1 | Access-port transaction completion pulse |
| ap_issue | output | 1 | Start accepted and forwarded to the access port |
| ap_block | output | 1 | High while a sticky flag blocks access-port traffic |
| bus_fault | input | 1 | Fault pulse that sets the sticky error flag |
| dbg_pwr_ack | input | 1 | Debug power acknowledge, asynchronous |
| sys_pwr_ack | input | 1 | System power acknowledge, asynchronous |
| dbg_pwr_req | output | 1 | Debug power-up request |
| sys_pwr_req | output | 1 | System power-up request |

## Verification
The overrun logic is driven with four start patterns against a transaction in flight: a start with detection enabled, a start with detection disabled, a start together with a done, and a start while already blocked. Together these separate a missing enable gate, a missing done priority and a missing block. The write-one-to-clear path is tried with a zero write, with a one write, and with a one write that coincides with a fault. This separates level-written flags and clear-over-set priority from correct behaviour. The acknowledge path is sampled after one edge and after two edges, which exposes a synchronizer that is one stage too short or too long.

// File: rtl/dbgcs_pkg.sv
package dbgcs_pkg;
    localparam int REG_W      = 32;
    localparam int SYNC_DEPTH = 2;
    localparam int B_ORUN_EN  = 0;
    localparam int B_ORUN     = 1;
    localparam int B_ERR      = 5;
    localparam int B_DREQ     = 28;
    localparam int B_DACK     = 29;
    localparam int B_SREQ     = 30;
    localparam int B_SACK     = 31;
    localparam logic [REG_W-1:0] USED_MASK =
        (REG_W'(1) << B_ORUN_EN) | (REG_W'(1) << B_ORUN) | (REG_W'(1) << B_ERR) |
        (REG_W'(1) << B_DREQ)    | (REG_W'(1) << B_DACK) |
        (REG_W'(1) << B_SREQ)    | (REG_W'(1) << B_SACK);

    typedef struct packed {
        logic orun_en;
        logic orun;
        logic err;
        logic dbg_req;
        logic sys_req;
    } csr_t;
endpackage

// File: rtl/dbgcs_ack_sync.sv
module dbgcs_ack_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] sh_d, sh_q;

        if (STAGES == 1) begin : g_one
            always_comb sh_d = async_in[g];
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], async_in[g]};
        end

        always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign sync_out[g] = sh_q[LAST];
    end
endmodule

// File: rtl/dbgcs_ap_tracker.sv
module dbgcs_ap_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    input  logic detect_en,
    input  logic blocked,
    output logic issue,
    output logic overrun,
    output logic busy
);
    logic busy_d, busy_q;
    logic collide;

    always_comb begin
        collide = start && busy_q && !done;
        overrun = !blocked && detect_en && collide;
        issue   = start && !blocked && !overrun;
        busy_d  = busy_q;
        if (done)  busy_d = 1'b0;
        if (issue) busy_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy_d;
    end

    assign busy = busy_q;
endmodule

// File: rtl/dbg_ctrlstat.sv
module dbg_ctrlstat
    import dbgcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             ap_start,
    input  logic             ap_done,
    output logic             ap_issue,
    output logic             ap_block,
    input  logic             bus_fault,
    input  logic             dbg_pwr_ack,
    input  logic             sys_pwr_ack,
    output logic             dbg_pwr_req,
    output logic             sys_pwr_req
);
    csr_t csr_d, csr_q;
    logic [1:0] ack_sync;
    logic       overrun_evt;
    logic       ap_busy;
    logic       unused_wdata;

    assign unused_wdata = ^(reg_wdata & ~USED_MASK) ^ reg_wdata[B_DACK] ^ reg_wdata[B_SACK];

    dbgcs_ack_sync #(.WIDTH(2), .STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sys_pwr_ack, dbg_pwr_ack}),
        .sync_out (ack_sync)
    );

    assign ap_block = csr_q.orun || csr_q.err;

    dbgcs_ap_tracker u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ap_start),
        .done      (ap_done),
        .detect_en (csr_q.orun_en),
        .blocked   (ap_block),
        .issue     (ap_issue),
        .overrun   (overrun_evt),
        .busy      (ap_busy)
    );

    always_comb begin
        csr_d = csr_q;
        if (reg_wr) begin
            csr_d.orun_en = reg_wdata[B_ORUN_EN];
            csr_d.dbg_req = reg_wdata[B_DREQ];
            csr_d.sys_req = reg_wdata[B_SREQ];
            if (reg_wdata[B_ORUN]) csr_d.orun = 1'b0;
            if (reg_wdata[B_ERR])  csr_d.err  = 1'b0;
        end
        if (overrun_evt) csr_d.orun = 1'b1;
        if (bus_fault)   csr_d.err  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) csr_q <= '0;
        else        csr_q <= csr_d;
    end

    always_comb begin
        reg_rdata            = '0;
        reg_rdata[B_ORUN_EN] = csr_q.orun_en;
        reg_rdata[B_ORUN]    = csr_q.orun;
        reg_rdata[B_ERR]     = csr_q.err;
        reg_rdata[B_DREQ]    = csr_q.dbg_req;
        reg_rdata[B_DACK]    = ack_sync[0];
        reg_rdata[B_SREQ]    = csr_q.sys_req;
        reg_rdata[B_SACK]    = ack_sync[1];
    end

    assign dbg_pwr_req = csr_q.dbg_req;
    assign sys_pwr_req = csr_q.sys_req;
endmodule

// File: rtl/dbg_ctrlstat_chk.sv
module dbg_ctrlstat_chk
    import dbgcs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             wr_clr_orun,
    input logic [REG_W-1:0] rdata,
    input logic             ap_start,
    input logic             ap_done,
    input logic             ap_issue,
    input logic             ap_block,
    input logic             bus_fault,
    input logic             dbg_req,
    input logic             sys_req,
    input logic             busy
);
    // R3
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_start && busy && !ap_done && rdata[B_ORUN_EN] && !ap_block) |=> rdata[B_ORUN]);
    // R4
    no_orun_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdata[B_ORUN_EN] && !rdata[B_ORUN]) |=> !rdata[B_ORUN]);
    // R5
    blocked_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ap_block |-> !ap_issue);
    // R6
    w1c_orun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && wr_clr_orun && !ap_start) |=> !rdata[B_ORUN]);
    // R8
    fault_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fault |=> rdata[B_ERR]);
    // R2
    req_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req == rdata[B_DREQ]) && (sys_req == rdata[B_SREQ]));
    // R11
    issue_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ap_issue |=> busy);
    // R12
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~USED_MASK) == '0);
endmodule

bind dbg_ctrlstat dbg_ctrlstat_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .wr_clr_orun (reg_wdata[1]),
    .rdata       (reg_rdata),
    .ap_start    (ap_start),
    .ap_done     (ap_done),
    .ap_issue    (ap_issue),
    .ap_block    (ap_block),
    .bus_fault   (bus_fault),
    .dbg_req     (dbg_pwr_req),
    .sys_req     (sys_pwr_req),
    .busy        (ap_busy)
);

// File: tb/dbg_ctrlstat_bench.sv
module dbg_ctrlstat_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ap_start = 1'b0, ap_done = 1'b0, ap_issue, ap_block;
    logic        bus_fault = 1'b0, dbg_pwr_ack = 1'b0, sys_pwr_ack = 1'b0;
    logic        dbg_pwr_req, sys_pwr_req;
    int          n_chk = 0, n_fail = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    dbg_ctrlstat u_dbg_ctrlstat (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ap_start(ap_start), .ap_done(ap_done),
        .ap_issue(ap_issue), .ap_block(ap_block), .bus_fault(bus_fault),
        .dbg_pwr_ack(dbg_pwr_ack), .sys_pwr_ack(sys_pwr_ack),
        .dbg_pwr_req(dbg_pwr_req), .sys_pwr_req(sys_pwr_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic start_pulse(input logic with_done, output logic issued);
        ap_start = 1'b1; ap_done = with_done;
        #1 issued = ap_issue;
        tick();
        ap_start = 1'b0; ap_done = 1'b0;
    endtask

    task automatic done_pulse();
        ap_done = 1'b1; tick(); ap_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 req", {30'b0, dbg_pwr_req, sys_pwr_req}, 32'h0);
        chk("R1 block", {31'b0, ap_block}, 32'h0);
    endtask

    task automatic t_req_and_ro();
        wr(32'hFFFF_FFFF & ~32'h22);
        chk("R2 R10 R12 read", reg_rdata, 32'h5000_0001);
        chk("R2 outputs", {30'b0, dbg_pwr_req, sys_pwr_req}, 32'h3);
        wr(32'h1000_0000);
        chk("R2 partial", reg_rdata, 32'h1000_0000);
        chk("R2 sys low", {31'b0, sys_pwr_req}, 32'h0);
    endtask

    task automatic t_ack_sync();
        dbg_pwr_ack = 1'b1;
        tick();
        chk("R9 dbg ack one edge", {31'b0, reg_rdata[29]}, 32'h0);
        tick();
        chk("R9 dbg ack two edges", {31'b0, reg_rdata[29]}, 32'h1);
        sys_pwr_ack = 1'b1;
        tick();
        chk("R9 sys ack one edge", {31'b0, reg_rdata[31]}, 32'h0);
        tick();
        chk("R9 sys ack two edges", {31'b0, reg_rdata[31]}, 32'h1);
        wr(32'h5000_0001);
        chk("R10 acks after write", reg_rdata, 32'hF000_0001);
    endtask

    task automatic t_overrun();
        logic iss;
        start_pulse(1'b0, iss);
        chk("R11 idle start issued", {31'b0, iss}, 32'h1);
        start_pulse(1'b1, iss);
        chk("R11 start with done issued", {31'b0, iss}, 32'h1);
        chk("R11 no overrun with done", {31'b0, reg_rdata[1]}, 32'h0);
        start_pulse(1'b0, iss);
        chk("R3 colliding start refused", {31'b0, iss}, 32'h0);
        chk("R3 overrun set", {31'b0, reg_rdata[1]}, 32'h1);
        chk("R5 block high", {31'b0, ap_block}, 32'h1);
        done_pulse();
        start_pulse(1'b0, iss);
        chk("R5 start refused while blocked", {31'b0, iss}, 32'h0);
        wr(32'hF000_0001);
        chk("R6 zero write keeps flag", {31'b0, reg_rdata[1]}, 32'h1);
        wr(32'h5000_0003);
        chk("R6 one write clears", {31'b0, reg_rdata[1]}, 32'h0);
        chk("R5 block released", {31'b0, ap_block}, 32'h0);
        start_pulse(1'b0, iss);
        chk("R5 refused start left idle", {31'b0, iss}, 32'h1);
        done_pulse();
    endtask

    task automatic t_disabled();
        logic iss;
        wr(32'h5000_0000);
        start_pulse(1'b0, iss);
        start_pulse(1'b0, iss);
        chk("R4 collide issued when disabled", {31'b0, iss}, 32'h1);
        chk("R4 no flag when disabled", {31'b0, reg_rdata[1]}, 32'h0);
        done_pulse();
    endtask

    task automatic t_fault();
        bus_fault = 1'b1; tick(); bus_fault = 1'b0;
        chk("R8 fault sets err", {31'b0, reg_rdata[5]}, 32'h1);
        chk("R5 err blocks", {31'b0, ap_block}, 32'h1);
        bus_fault = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h5000_0020;
        tick();
        bus_fault = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        chk("R7 set beats clear", {31'b0, reg_rdata[5]}, 32'h1);
        wr(32'h5000_0020);
        chk("R6 err cleared", {31'b0, reg_rdata[5]}, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_req_and_ro();
        t_ack_sync();
        t_overrun();
        t_disabled();
        t_fault();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule